// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block works out the order in which the column addresses of one SDRAM burst are presented. A controller pulses a start strobe with the requested column, a burst-length code and an ordering select. From the next clock on, the sequencer emits one column address per cycle, and the requested word always comes first. It then walks the rest of the aligned block that holds that word, either counting upward and wrapping inside the block, or combining the start offset with the beat count by exclusive-or.

The burst length and the ordering behave like mode-register fields. They are captured when the burst starts and stay fixed until it ends. Column bits above the burst field pass through untouched. A valid flag marks each beat and a last flag marks the final one. A new strobe that arrives during a burst cuts it short and starts the new one.

Top module: `bcs_sequencer`

## Requirements
- R1: While reset is asserted, and after it is released with no strobe, `valid_o` and `last_o` are 0.
- R2: A strobe sampled on a rising edge makes the next cycle show `valid_o`=1 with `col_o` equal to the `col_i` sampled with it. Beats then follow on consecutive cycles.
- R3: `bl_code_i` values 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats. `valid_o` stays high for exactly that many cycles when no strobe interrupts the burst.
- R4: With `ilv_i`=0 (sequential), beat k has low offset (s + k) mod BL, where s is the start column's offset within its BL-aligned block. Example: start 5, BL 4 gives 5,6,7,4.
- R5: With `ilv_i`=1 (interleaved), beat k has low offset s XOR k. Example: start 5, BL 8 gives 5,4,7,6,1,0,3,2.
- R6: Column bits above the low log2(BL) bits equal the start column's bits on every beat.
- R7: `last_o` is 1 only on the final beat of a burst, and only while `valid_o` is 1.
- R8: A strobe during a burst drops the remaining beats. The next cycle shows the first beat of the new burst.
- R9: Changes on `bl_code_i`, `ilv_i` or `col_i` while no strobe is sampled have no effect on the burst in progress.
- R10: A block-aligned start column gives ascending order in both orderings.
- R11: After the last beat, with no new strobe, `valid_o` returns to 0 and stays there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Burst start strobe |
| col_i | input | COL_W | Requested column address |
| bl_code_i | input | BL_CODE_W | Burst length code, BL = 2**code |
| ilv_i | input | 1 | Ordering: 0 sequential wrap, 1 interleaved |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | Beat present on `col_o` |
| last_o | output | 1 | Final beat of the burst |

## Verification
On every cycle, the assertions check several properties. The first beat must follow the strobe and carry the requested column. Each beat must step correctly against the one before it, for both orderings. The upper column bits must hold steady. The last flag must come only with a valid beat and on the beat whose count matches the captured length. The bench's scenarios are the only way to show the literal orders for specific start columns, and what happens when a burst is cut short by a restart. They also show that inputs changed in mid-burst are ignored, and that a reference queue agrees beat for beat across random strobes and lengths.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
   typedef enum logic {
      ORD_WRAP = 1'b0,
      ORD_XOR  = 1'b1
   } bcs_order_e;
endpackage

// File: rtl/bcs_mask_dec.sv
module bcs_mask_dec #(
   parameter int BL_CODE_W = 2,
   parameter int OFS_W     = 3
) (
   input  logic [BL_CODE_W-1:0] code_i,
   output logic [OFS_W-1:0]     mask_o
);
   // bit i of the offset field takes part in the burst when code > i
   for (genvar gi = 0; gi < OFS_W; gi++) begin : g_bit
      assign mask_o[gi] = (int'(code_i) > gi);
   end
endmodule

// File: rtl/bcs_beat_ctr.sv
module bcs_beat_ctr #(
   parameter int OFS_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [OFS_W-1:0] mask_i,
   output logic [OFS_W-1:0] ctr_o,
   output logic [OFS_W-1:0] mask_o,
   output logic             active_o,
   output logic             last_o
);
   logic [OFS_W-1:0] ctr_q;
   logic [OFS_W-1:0] mask_q;
   logic             active_q;
   logic             at_end;

   assign at_end = active_q && (ctr_q == mask_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctr_q    <= '0;
         mask_q   <= '0;
         active_q <= 1'b0;
      end else if (start_i) begin
         ctr_q    <= '0;
         mask_q   <= mask_i;
         active_q <= 1'b1;
      end else if (active_q) begin
         if (at_end) begin
            active_q <= 1'b0;
            ctr_q    <= '0;
         end else begin
            ctr_q <= ctr_q + 1'b1;
         end
      end
   end

   assign ctr_o    = ctr_q;
   assign mask_o   = mask_q;
   assign active_o = active_q;
   assign last_o   = at_end;
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
   import bcs_pkg::*;
#(
   parameter int COL_W = 10,
   parameter int OFS_W = 3
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [OFS_W-1:0] ctr_i,
   input  logic [OFS_W-1:0] mask_i,
   input  bcs_order_e       order_i,
   output logic [COL_W-1:0] col_o
);
   logic [OFS_W-1:0] wrap_sum;
   logic [OFS_W-1:0] xor_mix;

   // carries out of the burst field are dropped per bit by the mask below
   assign wrap_sum = base_i[OFS_W-1:0] + ctr_i;
   assign xor_mix  = base_i[OFS_W-1:0] ^ ctr_i;

   for (genvar gi = 0; gi < OFS_W; gi++) begin : g_ofs
      always_comb begin
         if (!mask_i[gi])
            col_o[gi] = base_i[gi];
         else if (order_i == ORD_XOR)
            col_o[gi] = xor_mix[gi];
         else
            col_o[gi] = wrap_sum[gi];
      end
   end

   if (COL_W > OFS_W) begin : g_upper
      assign col_o[COL_W-1:OFS_W] = base_i[COL_W-1:OFS_W];
   end
endmodule

// File: rtl/bcs_sequencer.sv
module bcs_sequencer
   import bcs_pkg::*;
#(
   parameter int COL_W     = 10,
   parameter int BL_CODE_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [COL_W-1:0]     col_i,
   input  logic [BL_CODE_W-1:0] bl_code_i,
   input  logic                 ilv_i,
   output logic [COL_W-1:0]     col_o,
   output logic                 valid_o,
   output logic                 last_o
);
   localparam int OFS_W = (1 << BL_CODE_W) - 1;

   if (BL_CODE_W < 1 || BL_CODE_W > 3) begin : g_bad_code_w
      $error("bcs_sequencer: BL_CODE_W must lie in 1..3");
   end
   if (COL_W <= OFS_W) begin : g_bad_col_w
      $error("bcs_sequencer: COL_W must exceed the widest burst field");
   end

   logic [OFS_W-1:0] mask_in;
   logic [OFS_W-1:0] mask_cur;
   logic [OFS_W-1:0] ctr;
   logic [COL_W-1:0] base_q;
   bcs_order_e       order_q;

   bcs_mask_dec #(.BL_CODE_W(BL_CODE_W), .OFS_W(OFS_W)) i_mask_dec (
      .code_i (bl_code_i),
      .mask_o (mask_in)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         order_q <= ORD_WRAP;
      end else if (start_i) begin
         base_q  <= col_i;
         order_q <= bcs_order_e'(ilv_i);
      end
   end

   bcs_beat_ctr #(.OFS_W(OFS_W)) i_beat_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .mask_i   (mask_in),
      .ctr_o    (ctr),
      .mask_o   (mask_cur),
      .active_o (valid_o),
      .last_o   (last_o)
   );

   bcs_addr_gen #(.COL_W(COL_W), .OFS_W(OFS_W)) i_addr_gen (
      .base_i  (base_q),
      .ctr_i   (ctr),
      .mask_i  (mask_cur),
      .order_i (order_q),
      .col_o   (col_o)
   );
endmodule

// File: rtl/bcs_sequencer_chk.sv
module bcs_sequencer_chk #(
   parameter int COL_W     = 10,
   parameter int BL_CODE_W = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 start_i,
   input logic [COL_W-1:0]     col_i,
   input logic [BL_CODE_W-1:0] bl_code_i,
   input logic                 ilv_i,
   input logic [COL_W-1:0]     col_o,
   input logic                 valid_o,
   input logic                 last_o
);
   localparam int OFS_W = (1 << BL_CODE_W) - 1;

   logic [COL_W-1:0] chk_mask;
   logic [COL_W-1:0] chk_s;
   logic             chk_ilv;
   int               chk_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_mask <= '0;
         chk_s    <= '0;
         chk_ilv  <= 1'b0;
         chk_cnt  <= 0;
      end else if (start_i) begin
         chk_mask <= COL_W'((1 << bl_code_i) - 1);
         chk_s    <= col_i;
         chk_ilv  <= ilv_i;
         chk_cnt  <= 1;
      end else if (valid_o && !last_o) begin
         chk_cnt  <= chk_cnt + 1;
      end
   end

   a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (valid_o && col_o == $past(col_i)));

   a_r3_len_match: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> (chk_cnt == int'(chk_mask) + 1));

   a_r3_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (chk_cnt <= int'(chk_mask) + 1));

   a_r4_wrap_step: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !last_o && !start_i && !chk_ilv) |=>
      ((col_o & chk_mask) == ((($past(col_o) & chk_mask) + 1'b1) & chk_mask)));

   a_r5_xor_step: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !last_o && !start_i && chk_ilv) |=>
      (((col_o ^ chk_s) & chk_mask) == (((($past(col_o) ^ chk_s) & chk_mask) + 1'b1) & chk_mask)));

   a_r6_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> ((col_o & ~chk_mask) == (chk_s & ~chk_mask)));

   a_r7_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);

   a_r11_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !start_i) |=> !valid_o);

   a_r11_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_o && !start_i) |=> !valid_o);
endmodule

bind bcs_sequencer bcs_sequencer_chk #(.COL_W(COL_W), .BL_CODE_W(BL_CODE_W)) i_chk (.*);

// File: tb/test_bcs_sequencer.sv
module test_bcs_sequencer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [9:0] col = '0;
   logic [1:0] blc = '0;
   logic       ilv = 1'b0;
   logic [9:0] col_o;
   logic       valid_o;
   logic       last_o;

   int    vecs = 0;
   int    fails = 0;
   bit    done = 0;
   string cur_req = "R1";

   typedef struct { int c; bit l; } beat_t;
   beat_t q[$];

   bcs_sequencer i_bcs_sequencer (
      .clk(clk), .rst_n(rst_n), .start_i(start), .col_i(col),
      .bl_code_i(blc), .ilv_i(ilv), .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
   );

   always #4 clk = ~clk;

   // reference: whole burst queued when a strobe is seen, one beat popped per edge
   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
      end else if (start) begin
         int bl, ofs, al;
         beat_t b;
         q.delete();
         bl  = 1 << blc;
         ofs = int'(col) % bl;
         al  = int'(col) - ofs;
         for (int k = 0; k < bl; k++) begin
            b.c = ilv ? al + (ofs ^ k) : al + ((ofs + k) % bl);
            b.l = (k == bl - 1);
            q.push_back(b);
         end
      end else if (q.size() > 0) begin
         void'(q.pop_front());
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         bit ev; int ec; bit el;
         ev = (q.size() > 0);
         ec = ev ? q[0].c : 0;
         el = ev ? q[0].l : 1'b0;
         vecs++;
         if (valid_o !== ev || last_o !== el || (ev && int'(col_o) != ec)) begin
            fails++;
            $display("FAIL %s: got valid=%0b last=%0b col=%0d, expected valid=%0b last=%0b col=%0d",
                     cur_req, valid_o, last_o, col_o, ev, el, ec);
         end
      end
   end

   task automatic issue(input int c, input int code, input bit i);
      @(negedge clk);
      start = 1'b1; col = 10'(c); blc = 2'(code); ilv = i;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic lit(input int c, input int code, input bit i, input int exp[], input string tag);
      cur_req = tag;
      issue(c, code, i);
      blc = ~blc; ilv = ~ilv; col = ~col;   // R9: ignored mid-burst
      for (int k = 0; k < exp.size(); k++) begin
         if (k > 0) @(negedge clk);
         vecs++;
         if (!valid_o || int'(col_o) != exp[k]) begin
            fails++;
            $display("FAIL %s: beat %0d got col=%0d valid=%0b, expected col=%0d valid=1",
                     tag, k, col_o, valid_o, exp[k]);
         end
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
         $finish;
      end
   end

   initial begin
      cur_req = "R1";
      idle(3);
      rst_n = 1'b1;
      idle(3);
      lit(5, 2, 0, '{5, 6, 7, 4}, "R4");
      lit(5, 3, 0, '{5, 6, 7, 0, 1, 2, 3, 4}, "R4");
      lit(5, 2, 1, '{5, 4, 7, 6}, "R5");
      lit(5, 3, 1, '{5, 4, 7, 6, 1, 0, 3, 2}, "R5");
      lit(8, 3, 0, '{8, 9, 10, 11, 12, 13, 14, 15}, "R10");
      lit(8, 3, 1, '{8, 9, 10, 11, 12, 13, 14, 15}, "R10");
      lit(757, 3, 0, '{757, 758, 759, 752, 753, 754, 755, 756}, "R6");
      lit(1021, 3, 1, '{1021, 1020, 1023, 1022, 1017, 1016, 1019, 1018}, "R6");
      lit(5, 0, 0, '{5}, "R3");
      lit(5, 1, 0, '{5, 4}, "R3");
      lit(5, 1, 1, '{5, 4}, "R3");
      lit(4, 1, 1, '{4, 5}, "R3");
      cur_req = "R11"; idle(5);
      cur_req = "R8";
      issue(3, 3, 0); idle(2);
      issue(14, 2, 1); idle(1);
      issue(33, 1, 0); idle(4);
      cur_req = "R9";
      issue(6, 3, 0);
      for (int k = 0; k < 6; k++) begin
         blc = 2'(k); ilv = k[0]; col = 10'(k * 77);
         @(negedge clk);
      end
      cur_req = "R7"; idle(4);
      cur_req = "R2";
      for (int n = 0; n < 400; n++) begin
         @(negedge clk);
         start = ($urandom_range(0, 3) == 0);
         col   = 10'($urandom);
         blc   = 2'($urandom);
         ilv   = 1'($urandom);
      end
      start = 1'b0;
      cur_req = "R11"; idle(12);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   end
endmodule